// File: doc/BRIEF.md
# Thread Block Resource Dispatcher

This block places thread blocks onto one multiprocessor. Upstream holds a queue of launch requests that all use one resource profile: a thread count, a register count per thread, a shared memory size and a barrier count. The block looks at the head of that queue. It takes the head block only when warp IDs, registers, shared memory and barriers are all free for the whole block at the same time. Otherwise the head waits. If the block could never fit even on an empty multiprocessor, a launch-fail flag is raised instead.

After it takes a block, the dispatcher reserves the block-level resources. It then creates one warp per 32 threads, rounded up, and issues one warp per cycle. Each warp gets a free warp ID in a sub-partition picked round-robin, and the warp keeps that placement for life. When a warp reports that it has finished, it enters a drain state. Its warp ID and registers are returned only once the warp's busy input (in-flight instructions) is low. Shared memory and barriers stay with the block until its last warp has been returned. In that cycle a block-done pulse carries the block's slot number upstream. Stalled warps are never evicted.

Top module: `blk_dispatch`

## Requirements
- R1: `blk_take` is high exactly when `blk_valid` is high, no warps are still being issued, and the block's warp count, register demand, shared memory and barriers each fit in the matching free amount. If any one does not fit, `blk_take` stays low and the request waits.
- R2: A taken block needs ceil(`cfg_threads`/32) warps. Its register demand is `cfg_regs` × 32 × that warp count. Each warp returns `cfg_regs` × 32 registers when it is released.
- R3: `spawn_valid` is high in the warps-count consecutive cycles that start one cycle after `blk_take`. In those cycles `spawn_blk` is the block's slot, which is the lowest-numbered slot not in use when the block was taken. `blk_take` is low while warps are being issued.
- R4: The sub-partition of each issued warp is the first one, starting at the round-robin pointer, that has a free warp ID. The pointer then moves to the sub-partition after it, wrapping, and it carries over between blocks (its value is 0 after reset). `spawn_wid` = sub-partition × WPS + the lowest free local index in it.
- R5: `wfin_valid` with the ID of a running warp puts that warp into drain. In each cycle, `wrel_valid` releases the lowest-numbered draining warp whose `warp_busy` bit is low, and `wrel_wid` gives its ID. One warp is released per cycle.
- R6: Shared memory and barriers of a block stay reserved until its last warp is released. In that same cycle, `blk_done` is high and `blk_done_id` gives the block slot.
- R7: A draining warp whose busy bit stays high is never released. Its block keeps all its resources, so a request that needs them is refused.
- R8: `launch_fail` is high when `blk_valid` is high and the profile is larger than the total warps, registers, shared memory or barriers. Such a request is never taken.
- R9: Resources freed by a release in some cycle count toward admission only from the next cycle.
- R10: After reset no resources are in use, and `blk_take`, `spawn_valid`, `wrel_valid` and `blk_done` are low.
- R11: `wfin_valid` naming a warp that is not running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A launch request is waiting at the head of the queue |
| cfg_threads | input | TW | Threads per block (1 or more) |
| cfg_regs | input | RW | Registers per thread |
| cfg_smem | input | SW | Shared memory bytes per block |
| cfg_bars | input | BW | Barriers per block |
| blk_take | output | 1 | Head request admitted this cycle |
| launch_fail | output | 1 | Head request can never fit |
| spawn_valid | output | 1 | One warp is issued this cycle |
| spawn_wid | output | IW | Warp ID of the issued warp |
| spawn_sp | output | PW | Sub-partition of the issued warp |
| spawn_blk | output | IW | Block slot of the issued warp |
| wfin_valid | input | 1 | A warp reports that all its threads are done |
| wfin_wid | input | IW | ID of the finished warp |
| warp_busy | input | NW | Per warp ID, instructions still in flight |
| wrel_valid | output | 1 | A drained warp is released this cycle |
| wrel_wid | output | IW | ID of the released warp |
| blk_done | output | 1 | Last warp of a block released this cycle |
| blk_done_id | output | IW | Slot of the completed block |

## Verification
The bench uses four sub-partitions of two warp IDs each, 2048 registers, 4096 bytes of shared memory and three barriers. These limits are small, so random profiles up to 256 threads and 10 registers per thread are often limited by a different resource each time. Some profiles are also too large for the whole multiprocessor. With only eight IDs, sub-partitions fill up fast, so the round-robin skip of a full sub-partition happens often. Block slots are reused in many different orders. Directed cases hold busy bits high to stall a block, release a block's last warp in the same cycle as a waiting request, and name warps that are not running.

// File: rtl/blk_dispatch.sv
module blk_dispatch #(
  parameter int N_SP = 4,
  parameter int WPS = 4,
  parameter int WARP = 32,
  parameter int REG_TOTAL = 4096,
  parameter int SMEM_TOTAL = 8192,
  parameter int BAR_TOTAL = 4,
  parameter int TW = 10,
  parameter int RW = 8,
  parameter int SW = 14,
  parameter int BW = 3,
  localparam int NW = N_SP * WPS,
  localparam int IW = $clog2(NW),
  localparam int PW = $clog2(N_SP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_valid,
  input  logic [TW-1:0] cfg_threads,
  input  logic [RW-1:0] cfg_regs,
  input  logic [SW-1:0] cfg_smem,
  input  logic [BW-1:0] cfg_bars,
  output logic          blk_take,
  output logic          launch_fail,
  output logic          spawn_valid,
  output logic [IW-1:0] spawn_wid,
  output logic [PW-1:0] spawn_sp,
  output logic [IW-1:0] spawn_blk,
  input  logic          wfin_valid,
  input  logic [IW-1:0] wfin_wid,
  input  logic [NW-1:0] warp_busy,
  output logic          wrel_valid,
  output logic [IW-1:0] wrel_wid,
  output logic          blk_done,
  output logic [IW-1:0] blk_done_id
);
  localparam int LW = $clog2(WPS);

  typedef enum logic [1:0] {W_FREE, W_RUN, W_DRAIN} wst_t;

  wst_t          wst   [NW];
  logic [IW-1:0] wblk  [NW];
  logic [IW:0]   live  [NW];
  logic [NW-1:0] bslot_used;
  logic [31:0]   used_w, used_r, used_s, used_b;
  logic [IW:0]   spawn_left;
  logic [IW-1:0] cur_blk, free_blk;
  logic [PW-1:0] rr, pick_sp;
  logic [LW-1:0] pick_loc;

  logic [31:0] need_w, reg_pw, need_r;
  logic        too_big, fits;

  assign need_w = (32'(cfg_threads) + 32'(WARP) - 32'd1) / 32'(WARP);
  assign reg_pw = 32'(cfg_regs) * 32'(WARP);
  assign need_r = need_w * reg_pw;

  assign too_big = need_w > 32'(NW) || need_r > 32'(REG_TOTAL) ||
                   32'(cfg_smem) > 32'(SMEM_TOTAL) || 32'(cfg_bars) > 32'(BAR_TOTAL);
  assign fits = need_w <= 32'(NW) - used_w &&
                need_r <= 32'(REG_TOTAL) - used_r &&
                32'(cfg_smem) <= 32'(SMEM_TOTAL) - used_s &&
                32'(cfg_bars) <= 32'(BAR_TOTAL) - used_b;

  assign launch_fail = blk_valid && too_big;
  assign blk_take    = blk_valid && !too_big && fits && spawn_left == '0;

  always_comb begin
    free_blk = '0;
    for (int b = NW - 1; b >= 0; b--)
      if (!bslot_used[b]) free_blk = IW'(b);
  end

  always_comb begin
    pick_sp  = rr;
    pick_loc = '0;
    for (int i = N_SP - 1; i >= 0; i--)
      for (int l = WPS - 1; l >= 0; l--)
        if (wst[((int'(rr) + i) % N_SP) * WPS + l] == W_FREE) begin
          pick_sp  = PW'((int'(rr) + i) % N_SP);
          pick_loc = LW'(l);
        end
  end

  assign spawn_valid = spawn_left != '0;
  assign spawn_sp    = pick_sp;
  assign spawn_wid   = IW'(int'(pick_sp) * WPS + int'(pick_loc));
  assign spawn_blk   = cur_blk;

  always_comb begin
    wrel_valid = 1'b0;
    wrel_wid   = '0;
    for (int i = NW - 1; i >= 0; i--)
      if (wst[i] == W_DRAIN && !warp_busy[i]) begin
        wrel_valid = 1'b1;
        wrel_wid   = IW'(i);
      end
  end

  assign blk_done_id = wblk[wrel_wid];
  assign blk_done    = wrel_valid && live[blk_done_id] == (IW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) begin
        wst[i]  <= W_FREE;
        wblk[i] <= '0;
        live[i] <= '0;
      end
      bslot_used <= '0;
      used_w     <= '0;
      used_r     <= '0;
      used_s     <= '0;
      used_b     <= '0;
      spawn_left <= '0;
      cur_blk    <= '0;
      rr         <= '0;
    end else begin
      used_w <= used_w + (blk_take ? need_w : 32'd0) - (wrel_valid ? 32'd1 : 32'd0);
      used_r <= used_r + (blk_take ? need_r : 32'd0) - (wrel_valid ? reg_pw : 32'd0);
      used_s <= used_s + (blk_take ? 32'(cfg_smem) : 32'd0) - (blk_done ? 32'(cfg_smem) : 32'd0);
      used_b <= used_b + (blk_take ? 32'(cfg_bars) : 32'd0) - (blk_done ? 32'(cfg_bars) : 32'd0);

      if (blk_take) begin
        bslot_used[free_blk] <= 1'b1;
        live[free_blk]       <= need_w[IW:0];
        cur_blk              <= free_blk;
        spawn_left           <= need_w[IW:0];
      end else if (spawn_valid) begin
        spawn_left      <= spawn_left - 1'b1;
        wst[spawn_wid]  <= W_RUN;
        wblk[spawn_wid] <= cur_blk;
        rr              <= (int'(pick_sp) == N_SP - 1) ? '0 : pick_sp + 1'b1;
      end

      if (wfin_valid && wst[wfin_wid] == W_RUN)
        wst[wfin_wid] <= W_DRAIN;

      if (wrel_valid) begin
        wst[wrel_wid]     <= W_FREE;
        live[blk_done_id] <= live[blk_done_id] - 1'b1;
        if (blk_done) bslot_used[blk_done_id] <= 1'b0;
      end
    end
  end

  // R1
  no_overcommit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_w <= 32'(NW) && used_r <= 32'(REG_TOTAL) &&
    used_s <= 32'(SMEM_TOTAL) && used_b <= 32'(BAR_TOTAL));

  // R8
  fail_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fail |-> !blk_take);

  // R3
  take_starts_spawn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_take |=> spawn_valid);

  // R3
  no_take_in_spawn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_valid |-> !blk_take);

  // R5
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrel_valid |-> !warp_busy[wrel_wid]);

  // R6
  done_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> wrel_valid);
endmodule

// File: tb/sim_blk_dispatch.sv
module sim_blk_dispatch;
  localparam int N_SP = 4, WPS = 2, REGT = 2048, SMT = 4096, BART = 3;
  localparam int NW = N_SP * WPS, IW = 3, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          blk_valid = 0, wfin_valid = 0;
  logic [9:0]    cfg_threads = 10'd32;
  logic [7:0]    cfg_regs = 8'd1;
  logic [13:0]   cfg_smem = '0;
  logic [2:0]    cfg_bars = '0;
  logic [IW-1:0] wfin_wid = '0;
  logic [NW-1:0] warp_busy = '0;
  logic blk_take, launch_fail, spawn_valid, wrel_valid, blk_done;
  logic [IW-1:0] spawn_wid, spawn_blk, wrel_wid, blk_done_id;
  logic [PW-1:0] spawn_sp;

  blk_dispatch #(.N_SP(N_SP), .WPS(WPS), .WARP(32), .REG_TOTAL(REGT), .SMEM_TOTAL(SMT),
                 .BAR_TOTAL(BART), .TW(10), .RW(8), .SW(14), .BW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .cfg_threads(cfg_threads),
    .cfg_regs(cfg_regs), .cfg_smem(cfg_smem), .cfg_bars(cfg_bars),
    .blk_take(blk_take), .launch_fail(launch_fail), .spawn_valid(spawn_valid),
    .spawn_wid(spawn_wid), .spawn_sp(spawn_sp), .spawn_blk(spawn_blk),
    .wfin_valid(wfin_valid), .wfin_wid(wfin_wid), .warp_busy(warp_busy),
    .wrel_valid(wrel_valid), .wrel_wid(wrel_wid), .blk_done(blk_done),
    .blk_done_id(blk_done_id));

  int nchk = 0, nfail = 0;
  int mst[NW], mblk[NW], mlive[NW], mbused[NW];
  int uw = 0, ur = 0, us = 0, ub = 0, mleft = 0, mcur = 0, mrr = 0;
  int d_valid = 0, d_thr = 32, d_rpt = 1, d_smem = 0, d_bars = 0, d_wfv = 0, d_wfid = 0;
  logic [NW-1:0] d_busy = '0;

  task automatic chk(int act, int exp, string tag);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    int nw, nr, s, wid, rw, fb, b;
    bit big, etk, esv, erel, edone;
    @(negedge clk);
    blk_valid = d_valid[0]; cfg_threads = 10'(d_thr); cfg_regs = 8'(d_rpt);
    cfg_smem = 14'(d_smem); cfg_bars = 3'(d_bars);
    wfin_valid = d_wfv[0]; wfin_wid = IW'(d_wfid); warp_busy = d_busy;
    #1;
    nw = (d_thr + 31) / 32;
    nr = d_rpt * 32 * nw;
    big = nw > NW || nr > REGT || d_smem > SMT || d_bars > BART;
    etk = d_valid[0] && !big && mleft == 0 && nw <= NW - uw && nr <= REGT - ur &&
          d_smem <= SMT - us && d_bars <= BART - ub;
    chk(int'(blk_take), int'(etk), "R1 blk_take");
    chk(int'(launch_fail), int'(d_valid[0] && big), "R8 launch_fail");
    esv = mleft > 0;
    chk(int'(spawn_valid), int'(esv), "R2 R3 spawn_valid");
    s = -1; wid = -1;
    if (esv) begin
      for (int i = 0; i < N_SP && s < 0; i++)
        for (int l = 0; l < WPS && s < 0; l++)
          if (mst[((mrr + i) % N_SP) * WPS + l] == 0) begin
            s = (mrr + i) % N_SP; wid = s * WPS + l;
          end
      chk(int'(spawn_sp), s, "R4 spawn_sp");
      chk(int'(spawn_wid), wid, "R4 spawn_wid");
      chk(int'(spawn_blk), mcur, "R3 spawn_blk");
    end
    rw = -1;
    for (int i = NW - 1; i >= 0; i--) if (mst[i] == 2 && !d_busy[i]) rw = i;
    erel = rw >= 0;
    chk(int'(wrel_valid), int'(erel), "R5 wrel_valid");
    edone = erel && mlive[mblk[rw]] == 1;
    if (erel) chk(int'(wrel_wid), rw, "R5 wrel_wid");
    chk(int'(blk_done), int'(edone), "R6 blk_done");
    if (edone) chk(int'(blk_done_id), mblk[rw], "R6 blk_done_id");
    fb = -1;
    for (int i = NW - 1; i >= 0; i--) if (mbused[i] == 0) fb = i;
    if (d_wfv[0] && mst[d_wfid] == 1) mst[d_wfid] = 2;
    if (erel) begin
      b = mblk[rw]; mst[rw] = 0; uw--; ur -= d_rpt * 32; mlive[b]--;
      if (edone) begin mbused[b] = 0; us -= d_smem; ub -= d_bars; end
    end
    if (esv) begin
      mst[wid] = 1; mblk[wid] = mcur; mrr = (s + 1) % N_SP; mleft--;
    end
    if (etk) begin
      uw += nw; ur += nr; us += d_smem; ub += d_bars;
      mbused[fb] = 1; mlive[fb] = nw; mcur = fb; mleft = nw;
    end
  endtask

  function automatic int pick_run();
    int c, k;
    c = 0;
    for (int i = 0; i < NW; i++) if (mst[i] == 1) c++;
    if (c == 0) return -1;
    k = int'($urandom % c);
    for (int i = 0; i < NW; i++)
      if (mst[i] == 1) begin
        if (k == 0) return i;
        k--;
      end
    return -1;
  endfunction

  task automatic set_prof(int t, int r, int sm, int br);
    d_thr = t; d_rpt = r; d_smem = sm; d_bars = br;
  endtask

  task automatic drain();
    int w;
    d_valid = 0; d_busy = '0;
    for (int n = 0; n < 600 && (uw != 0 || mleft != 0); n++) begin
      w = pick_run();
      d_wfv = (w >= 0) ? 1 : 0; d_wfid = (w >= 0) ? w : 0;
      tick();
    end
    d_wfv = 0;
  endtask

  task automatic run_random(int cycles);
    int w;
    for (int n = 0; n < cycles; n++) begin
      d_valid = ($urandom % 10) < 7 ? 1 : 0;
      for (int i = 0; i < NW; i++) d_busy[i] = ($urandom % 10) < 3;
      d_wfv = 0;
      if ($urandom % 2 == 1) begin
        if ($urandom % 8 == 0) begin
          d_wfv = 1; d_wfid = int'($urandom % NW);  // R11: may name a non-running warp
        end else begin
          w = pick_run();
          if (w >= 0) begin d_wfv = 1; d_wfid = w; end
        end
      end
      tick();
    end
  endtask

  function automatic int warp_of(int blk, int skip);
    for (int i = 0; i < NW; i++) if (mst[i] == 1 && mblk[i] == blk && i != skip) return i;
    return -1;
  endfunction

  initial begin
    int wa, wb;
    for (int i = 0; i < NW; i++) begin mst[i] = 0; mblk[i] = 0; mlive[i] = 0; mbused[i] = 0; end
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk(int'(blk_take), 0, "R10 take");
    chk(int'(spawn_valid), 0, "R10 spawn");
    chk(int'(wrel_valid), 0, "R10 release");
    chk(int'(blk_done), 0, "R10 done");

    // R9: last warp released in the same cycle as a waiting request
    set_prof(64, 16, 100, 1);
    d_valid = 1;
    repeat (7) tick();
    chk(uw, 4, "R1 two blocks resident");
    chk(int'(blk_take), 0, "R1 register limit refuses third");
    d_busy = '1;
    wa = warp_of(0, -1); wb = warp_of(0, wa);
    d_wfv = 1; d_wfid = wa; tick();
    d_wfid = wb; tick();
    d_wfv = 0; tick();
    d_busy = '0;
    tick();
    chk(int'(wrel_valid), 1, "R5 first release");
    tick();
    chk(int'(blk_done), 1, "R6 block 0 done");
    chk(int'(blk_take), 0, "R9 freed regs not yet visible");
    tick();
    chk(int'(blk_take), 1, "R9 freed regs visible next cycle");
    drain();

    // R7: stalled warp keeps its block's resources
    set_prof(32, 64, 10, 1);
    d_valid = 1;
    repeat (2) tick();
    wa = warp_of(mcur, -1);
    d_busy = '1; d_wfv = 1; d_wfid = (wa >= 0) ? wa : 0;
    tick();
    d_wfv = 0;
    for (int n = 0; n < 20; n++) begin
      tick();
      chk(int'(wrel_valid), 0, "R7 no release while busy");
      chk(int'(blk_take), 0, "R7 resources still held");
    end
    d_busy = '0;
    tick();
    chk(int'(blk_done), 1, "R7 done after busy drops");
    tick();
    chk(int'(blk_take), 1, "R7 next block admitted");
    drain();

    // R11: finish report for a free warp is ignored
    d_wfv = 1; d_wfid = 5; tick();
    d_wfv = 0; tick();
    chk(int'(wrel_valid), 0, "R11 no release");
    chk(uw, 0, "R11 nothing reserved");

    // R8: profiles too large for the whole multiprocessor
    set_prof(300, 1, 0, 0); d_valid = 1;
    repeat (3) tick();
    chk(int'(launch_fail), 1, "R8 too many warps");
    set_prof(32, 1, 5000, 0); tick();
    chk(int'(launch_fail), 1, "R8 too much shared memory");
    d_valid = 0; tick();
    chk(int'(launch_fail), 0, "R8 idle clears flag");

    for (int ph = 0; ph < 10; ph++) begin
      set_prof(1 + int'($urandom % 256), 1 + int'($urandom % 10),
               int'($urandom % 4500), int'($urandom % 4));
      run_random(1500);
      drain();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule